// File: doc/BRIEF.md
# Instruction Decode and Execute Unit

This block is the purely combinational decode and execute slice of a small five-stage scalar pipeline built around a 16-bit instruction word and 8-bit data. The enclosing pipeline supplies three things. The first is the instruction word held in the decode stage. The second is the two values read from the register file. The third is the address of that instruction. From these the block produces three groups of outputs:

- the register indices to read and to write, with an enable flag for each;
- the register-write and memory-access controls;
- the ALU result or effective address, the branch target and the branch decision.

The opcode sits in bits [15:12]. The other fields move with the opcode:

- Three-register operations carry a destination and two sources.
- `INC` reads and writes the same register.
- `LOAD` and `STORE` add a signed 4-bit displacement to a base register.
- `JMP` carries a signed 8-bit displacement in bits [11:4].
- `BEQZ` carries a test register and a signed 8-bit displacement in bits [7:0].

Branch displacements count 2-byte instruction slots. They are measured from the address of the branch plus 2.

Pipeline registers, the register file and both memories live outside the block. On the read side, `opnd_a` must carry the value of register `src_a_idx` and `opnd_b` the value of `src_b_idx`. For a store, `opnd_b` is the data to be written.

Top module: `idex_unit`

## Requirements
- R1: For opcodes 0000 (add), 0001 (subtract), 0010 (multiply), 0100 (and), 0101 (or) and 0111 (xor), the fields are fixed: `dst_idx` = instr[11:8], `src_a_idx` = instr[7:4] and `src_b_idx` = instr[3:0]. Both source enables and `reg_we` are 1. `result` is `opnd_a` op `opnd_b`, kept to the low 8 bits (two's complement).
- R2: Opcode 0011 (increment) sets `dst_idx` and `src_a_idx` to instr[11:8] and sets `src_a_en`. `src_b_en` is 0 and `reg_we` is 1. `result` = `opnd_a` + 1, modulo 256.
- R3: Opcode 0110 (complement) sets `dst_idx` = instr[11:8], `src_a_idx` = instr[7:4] and `reg_we` = 1. `result` = ~`opnd_a`. instr[3:0] and `opnd_b` have no effect, and `src_b_en` is 0.
- R4: Opcode 1000 (load) sets `dst_idx` = instr[11:8], `src_a_idx` = instr[7:4], `mem_rd` = 1 and `reg_we` = 1. `result` = `opnd_a` + sign-extended instr[3:0].
- R5: Opcode 1001 (store) sets `src_a_idx` = instr[7:4] as the base and `src_b_idx` = instr[11:8] as the data. `mem_wr` is 1 and `reg_we` is 0. `result` = `opnd_a` + sign-extended instr[3:0].
- R6: Opcode 1010 (jump) sets `br_taken` = 1. `br_target` = `pc` + 2 + 2 × sign-extended instr[11:4], modulo 2^PC_W. No register or memory control is raised.
- R7: Opcode 1011 (branch if zero) sets `src_a_idx` = instr[11:8]. `br_target` = `pc` + 2 + 2 × sign-extended instr[7:0]. `br_taken` is 1 exactly when `opnd_a` is zero.
- R8: Opcode 1111 (halt) sets `halt` = 1. It raises no register write, memory access or branch.
- R9: Opcodes 1100, 1101 and 1110 decode as no-ops. Every output is 0.
- R10: An output that an opcode does not use is 0. `result` is 0 for branch, halt and no-op. `br_target` is 0 for non-branch opcodes. Unused indices and enables are 0.
- R11: `mem_rd` and `mem_wr` are never both 1, and `br_taken` is 1 only for opcodes 1010 and 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word in the decode stage |
| opnd_a | input | DATA_W | Value of register `src_a_idx` |
| opnd_b | input | DATA_W | Value of register `src_b_idx` |
| pc | input | PC_W | Byte address of this instruction |
| dst_idx | output | 4 | Register to be written |
| src_a_idx | output | 4 | First register to read |
| src_b_idx | output | 4 | Second register to read |
| src_a_en | output | 1 | First source is used |
| src_b_en | output | 1 | Second source is used |
| reg_we | output | 1 | Instruction writes `dst_idx` |
| mem_rd | output | 1 | Instruction reads data memory |
| mem_wr | output | 1 | Instruction writes data memory (data = `opnd_b`) |
| result | output | DATA_W | ALU result or effective address |
| br_target | output | PC_W | Branch destination address |
| br_taken | output | 1 | Control transfer is taken |
| halt | output | 1 | Halt instruction decoded |

## Verification
The block holds no state, so any fault in decode or arithmetic shows at the ports in the same evaluation that presents the instruction. A misplaced field shows up as a wrong register index. A wrong sign extension shows up as an effective address or target that is off by a multiple of 16 or 256. A swapped control bit shows up as a stray write enable. The table of vectors covers every opcode with operand values chosen to hit carries, wrap-around and negative displacements. Sweeps then cover every load displacement and every value of the tested register in branch-if-zero.

// File: rtl/idex_pkg.sv
package idex_pkg;

    localparam int INSTR_W = 16;
    localparam int REG_W   = 4;
    localparam int BOFF_W  = 8;
    localparam int MOFF_W  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_INC  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_NOT  = 4'h6,
        OP_XOR  = 4'h7,
        OP_LOAD = 4'h8,
        OP_STOR = 4'h9,
        OP_JMP  = 4'hA,
        OP_BEQZ = 4'hB,
        OP_HALT = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_NONE,
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOT
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG,
        SRCB_ONE,
        SRCB_DISP
    } srcb_e;

    typedef struct packed {
        alu_op_e          alu_op;
        srcb_e            srcb;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic             src_a_en;
        logic             src_b_en;
        logic             reg_we;
        logic             mem_rd;
        logic             mem_wr;
        logic             is_jmp;
        logic             is_beqz;
        logic             halt;
    } ctrl_t;

    function automatic logic [3:0] opcode_of(input logic [INSTR_W-1:0] w);
        return w[15:12];
    endfunction

    function automatic logic is_branch_op(input logic [3:0] op);
        return (op == OP_JMP) || (op == OP_BEQZ);
    endfunction

endpackage

// File: rtl/idex_decoder.sv
module idex_decoder
    import idex_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);
    logic [REG_W-1:0] f_hi, f_mid, f_lo;

    assign f_hi  = instr[11:8];
    assign f_mid = instr[7:4];
    assign f_lo  = instr[3:0];

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_NONE;
        ctrl.srcb   = SRCB_REG;
        case (opcode_of(instr))
            OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR: begin
                ctrl.dst      = f_hi;
                ctrl.src_a    = f_mid;
                ctrl.src_b    = f_lo;
                ctrl.src_a_en = 1'b1;
                ctrl.src_b_en = 1'b1;
                ctrl.reg_we   = 1'b1;
                case (opcode_of(instr))
                    OP_ADD:  ctrl.alu_op = ALU_ADD;
                    OP_SUB:  ctrl.alu_op = ALU_SUB;
                    OP_MUL:  ctrl.alu_op = ALU_MUL;
                    OP_AND:  ctrl.alu_op = ALU_AND;
                    OP_OR:   ctrl.alu_op = ALU_OR;
                    default: ctrl.alu_op = ALU_XOR;
                endcase
            end
            OP_INC: begin
                ctrl.dst      = f_hi;
                ctrl.src_a    = f_hi;
                ctrl.src_a_en = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = ALU_ADD;
                ctrl.srcb     = SRCB_ONE;
            end
            OP_NOT: begin
                ctrl.dst      = f_hi;
                ctrl.src_a    = f_mid;
                ctrl.src_a_en = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = ALU_NOT;
            end
            OP_LOAD: begin
                ctrl.dst      = f_hi;
                ctrl.src_a    = f_mid;
                ctrl.src_a_en = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.mem_rd   = 1'b1;
                ctrl.alu_op   = ALU_ADD;
                ctrl.srcb     = SRCB_DISP;
            end
            OP_STOR: begin
                ctrl.src_a    = f_mid;
                ctrl.src_b    = f_hi;
                ctrl.src_a_en = 1'b1;
                ctrl.src_b_en = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.alu_op   = ALU_ADD;
                ctrl.srcb     = SRCB_DISP;
            end
            OP_JMP: begin
                ctrl.is_jmp = 1'b1;
            end
            OP_BEQZ: begin
                ctrl.src_a    = f_hi;
                ctrl.src_a_en = 1'b1;
                ctrl.is_beqz  = 1'b1;
            end
            OP_HALT: begin
                ctrl.halt = 1'b1;
            end
            default: begin
                ctrl.halt = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown(instr)) begin
            // R11
            mem_excl_chk: assert (!(ctrl.mem_rd && ctrl.mem_wr))
                else $error("decoder raised both memory strobes");
            // R10
            idle_src_chk: assert (ctrl.src_a_en || (ctrl.src_a == '0))
                else $error("unused source index not zero");
        end
    end
endmodule

// File: rtl/idex_alu.sv
module idex_alu
    import idex_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             alu_op,
    input  srcb_e               srcb,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [MOFF_W-1:0]   disp,
    output logic [DATA_W-1:0]   y
);
    logic [DATA_W-1:0] disp_ext;
    logic [DATA_W-1:0] rhs;

    assign disp_ext = DATA_W'($signed(disp));

    always_comb begin
        case (srcb)
            SRCB_ONE:  rhs = DATA_W'(1);
            SRCB_DISP: rhs = disp_ext;
            default:   rhs = b;
        endcase
    end

    always_comb begin
        case (alu_op)
            ALU_ADD: y = a + rhs;
            ALU_SUB: y = a - rhs;
            ALU_MUL: y = DATA_W'(a * rhs);
            ALU_AND: y = a & rhs;
            ALU_OR:  y = a | rhs;
            ALU_XOR: y = a ^ rhs;
            ALU_NOT: y = ~a;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({alu_op, srcb, a})) begin
            // R2
            inc_wrap_chk: assert (!(alu_op == ALU_ADD && srcb == SRCB_ONE && a == '1) || y == '0)
                else $error("increment of all-ones did not wrap");
        end
    end

    initial begin
        if (DATA_W <= MOFF_W) $error("DATA_W must exceed the displacement width");
    end
endmodule

// File: rtl/idex_branch.sv
module idex_branch
    import idex_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [PC_W-1:0]    pc,
    input  logic [DATA_W-1:0]  a,
    input  logic               is_jmp,
    input  logic               is_beqz,
    output logic [PC_W-1:0]    target,
    output logic               taken
);
    logic [BOFF_W-1:0] disp;
    logic [PC_W-1:0]   disp_ext;
    logic [PC_W-1:0]   seq_pc;

    assign disp     = is_jmp ? instr[11:4] : instr[7:0];
    assign disp_ext = PC_W'($signed(disp));
    assign seq_pc   = pc + PC_W'(2);

    always_comb begin
        target = '0;
        taken  = 1'b0;
        if (is_jmp || is_beqz) begin
            target = seq_pc + (disp_ext << 1);
            taken  = is_jmp || (a == '0);
        end
    end

    always_comb begin
        if (!$isunknown({is_jmp, is_beqz, a})) begin
            // R7
            beqz_nonzero_chk: assert (!(is_beqz && a != '0) || !taken)
                else $error("branch-if-zero taken on nonzero operand");
        end
    end

    initial begin
        if (PC_W < BOFF_W) $error("PC_W must be at least the branch displacement width");
    end
endmodule

// File: rtl/idex_unit.sv
module idex_unit
    import idex_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8
) (
    input  logic [15:0]        instr,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [PC_W-1:0]    pc,
    output logic [3:0]         dst_idx,
    output logic [3:0]         src_a_idx,
    output logic [3:0]         src_b_idx,
    output logic               src_a_en,
    output logic               src_b_en,
    output logic               reg_we,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  result,
    output logic [PC_W-1:0]    br_target,
    output logic               br_taken,
    output logic               halt
);
    ctrl_t ctrl;

    idex_decoder u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    idex_alu #(.DATA_W(DATA_W)) u_alu (
        .alu_op (ctrl.alu_op),
        .srcb   (ctrl.srcb),
        .a      (opnd_a),
        .b      (opnd_b),
        .disp   (instr[3:0]),
        .y      (result)
    );

    idex_branch #(.DATA_W(DATA_W), .PC_W(PC_W)) u_br (
        .instr   (instr),
        .pc      (pc),
        .a       (opnd_a),
        .is_jmp  (ctrl.is_jmp),
        .is_beqz (ctrl.is_beqz),
        .target  (br_target),
        .taken   (br_taken)
    );

    assign dst_idx   = ctrl.dst;
    assign src_a_idx = ctrl.src_a;
    assign src_b_idx = ctrl.src_b;
    assign src_a_en  = ctrl.src_a_en;
    assign src_b_en  = ctrl.src_b_en;
    assign reg_we    = ctrl.reg_we;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign halt      = ctrl.halt;

    always_comb begin
        if (!$isunknown({instr, opnd_a})) begin
            // R11
            taken_needs_branch_chk: assert (!br_taken || is_branch_op(opcode_of(instr)))
                else $error("taken raised by a non-branch opcode");
            // R5
            store_no_we_chk: assert (!mem_wr || !reg_we)
                else $error("store also writes a register");
            // R9
            nop_quiet_chk: assert (!(instr[15:14] == 2'b11 && instr[13:12] != 2'b11)
                                   || !(reg_we || mem_rd || mem_wr || br_taken || halt))
                else $error("reserved opcode raised a control");
            // R8
            halt_quiet_chk: assert (!halt || !(reg_we || mem_wr || br_taken))
                else $error("halt raised another control");
        end
    end
endmodule

// File: tb/idex_unit_tb.sv
module idex_unit_tb;
    localparam int DW = 8;
    localparam int PW = 8;

    typedef struct packed {
        logic [15:0] instr;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  pc;
        logic [7:0]  res;
        logic [3:0]  rd;
        logic [3:0]  rs1;
        logic [3:0]  rs2;
        logic        e1;
        logic        e2;
        logic        we;
        logic        mrd;
        logic        mwr;
        logic        tk;
        logic [7:0]  tgt;
        logic        hlt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{16'h0123, 8'h7F, 8'h01, 8'h00, 8'h80, 4'h1, 4'h2, 4'h3, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 add carry into sign
        '{16'h1456, 8'h05, 8'h07, 8'h00, 8'hFE, 4'h4, 4'h5, 4'h6, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 sub negative
        '{16'h2789, 8'h10, 8'h11, 8'h00, 8'h10, 4'h7, 4'h8, 4'h9, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 mul truncated
        '{16'h3A00, 8'hFF, 8'h55, 8'h00, 8'h00, 4'hA, 4'hA, 4'h0, 1, 0, 1, 0, 0, 0, 8'h00, 0, 4'd2}, // R2 inc wraps
        '{16'h4123, 8'hF0, 8'h3C, 8'h00, 8'h30, 4'h1, 4'h2, 4'h3, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 and
        '{16'h5123, 8'hF0, 8'h0C, 8'h00, 8'hFC, 4'h1, 4'h2, 4'h3, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 or
        '{16'h62F5, 8'h5A, 8'hFF, 8'h00, 8'hA5, 4'h2, 4'hF, 4'h0, 1, 0, 1, 0, 0, 0, 8'h00, 0, 4'd3}, // R3 not, low bits ignored
        '{16'h7123, 8'hFF, 8'h0F, 8'h00, 8'hF0, 4'h1, 4'h2, 4'h3, 1, 1, 1, 0, 0, 0, 8'h00, 0, 4'd1}, // R1 xor
        '{16'h834F, 8'h10, 8'h00, 8'h00, 8'h0F, 4'h3, 4'h4, 4'h0, 1, 0, 1, 1, 0, 0, 8'h00, 0, 4'd4}, // R4 load, disp -1
        '{16'h8347, 8'hFC, 8'h00, 8'h00, 8'h03, 4'h3, 4'h4, 4'h0, 1, 0, 1, 1, 0, 0, 8'h00, 0, 4'd4}, // R4 load, wrap
        '{16'h9568, 8'h20, 8'h77, 8'h00, 8'h18, 4'h0, 4'h6, 4'h5, 1, 1, 0, 0, 1, 0, 8'h00, 0, 4'd5}, // R5 store, disp -8
        '{16'hA7F0, 8'h00, 8'h00, 8'h10, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 1, 8'h10, 0, 4'd6}, // R6 max forward
        '{16'hA800, 8'h00, 8'h00, 8'h40, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 1, 8'h42, 0, 4'd6}, // R6 max backward
        '{16'hAFF0, 8'h33, 8'h00, 8'h20, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 1, 8'h20, 0, 4'd6}, // R6 self loop
        '{16'hB3FE, 8'h00, 8'h00, 8'h30, 8'h00, 4'h0, 4'h3, 4'h0, 1, 0, 0, 0, 0, 1, 8'h2E, 0, 4'd7}, // R7 taken
        '{16'hB305, 8'h01, 8'h00, 8'h30, 8'h00, 4'h0, 4'h3, 4'h0, 1, 0, 0, 0, 0, 0, 8'h3C, 0, 4'd7}, // R7 not taken
        '{16'hFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 4'd8}, // R8 halt
        '{16'hC123, 8'h00, 8'h00, 8'h10, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 4'd9}, // R9 reserved 1100
        '{16'hD000, 8'h00, 8'h00, 8'h10, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 4'd9}, // R9 reserved 1101
        '{16'hEFFF, 8'hAA, 8'h55, 8'h10, 8'h00, 4'h0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 4'd9}  // R9 R10 reserved 1110
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] instr = '0;
    logic [7:0]  opnd_a = '0, opnd_b = '0, pc = '0;
    logic [3:0]  dst_idx, src_a_idx, src_b_idx;
    logic        src_a_en, src_b_en, reg_we, mem_rd, mem_wr, br_taken, halt;
    logic [7:0]  result, br_target;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    idex_unit #(.DATA_W(DW), .PC_W(PW)) u_dut (
        .instr, .opnd_a, .opnd_b, .pc,
        .dst_idx, .src_a_idx, .src_b_idx, .src_a_en, .src_b_en,
        .reg_we, .mem_rd, .mem_wr, .result, .br_target, .br_taken, .halt
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] i, input logic [7:0] a, input logic [7:0] b, input logic [7:0] p);
        @(negedge clk);
        instr = i; opnd_a = a; opnd_b = b; pc = p;
        #1;
    endtask

    function automatic logic [63:0] pack_out();
        return {20'd0, result, dst_idx, src_a_idx, src_b_idx, src_a_en, src_b_en,
                reg_we, mem_rd, mem_wr, br_taken, br_target, halt};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // Initial state: all-zero inputs decode as add r0,r0,r0 (R1, R10)
        apply(16'h0000, 8'h00, 8'h00, 8'h00);
        check("R1 idle add r0", pack_out(),
              {20'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0});

        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            apply(v.instr, v.a, v.b, v.pc);
            check($sformatf("R%0d vector %0d", v.req, k), pack_out(),
                  {20'd0, v.res, v.rd, v.rs1, v.rs2, v.e1, v.e2, v.we, v.mrd, v.mwr, v.tk, v.tgt, v.hlt});
        end

        // R3: complement result independent of instr[3:0] and opnd_b
        for (int k = 0; k < 16; k++) begin
            apply({4'h6, 4'h1, 4'h2, 4'(k)}, 8'h3C, 8'(k * 17), 8'h00);
            check("R3 not ignores low field", {56'd0, result}, 64'hC3);
        end

        // R4: every load displacement
        for (int k = 0; k < 16; k++) begin
            logic [7:0] ea;
            ea = 8'h80 + {{4{k[3]}}, 4'(k)};
            apply({4'h8, 4'h2, 4'h7, 4'(k)}, 8'h80, 8'h00, 8'h00);
            check("R4 load displacement", {56'd0, result}, {56'd0, ea});
        end

        // R7: taken only for zero operand
        for (int k = 0; k < 256; k++) begin
            apply(16'hB900, 8'(k), 8'h00, 8'hF0);
            check("R7 zero test", {55'd0, br_taken, br_target}, {55'd0, (k == 0), 8'hF2});
        end

        // R11: strobes exclusive, taken only on branches, over every opcode
        for (int k = 0; k < 16; k++) begin
            apply({4'(k), 12'h000}, 8'h00, 8'h00, 8'h00);
            check("R11 strobes exclusive", {63'd0, mem_rd & mem_wr}, 64'd0);
            check("R11 taken only on branch", {63'd0, br_taken}, {63'd0, (k == 10 || k == 11)});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule